// File: doc/BRIEF.md
# Memory-Mapped I/O Address Decoder

This block sits on the data side of a small 16-bit processor, between the CPU's load/store port and its word-addressed RAM. The address space holds 65536 words of 16 bits. Three fixed word addresses are taken over by devices instead of memory.

A store to the character address hands the low byte of the write data, an ASCII code, to a screen stream. A store of the value 1 to the clear address fires a screen-clear strobe. A load from the random address returns the current state of an internal 16-bit LFSR and steps it, so every load sees a fresh word. None of these accesses reaches RAM. Every other access passes straight through to the RAM port with no added latency.

Reset is asynchronous and active low. Its release is synchronised inside the block, so the logic leaves reset two clock edges after `rst_n` rises. The RAM path is purely combinational. The screen strobes are registered and appear in the cycle after the store that caused them.

Top module: `mmio_steer`

## Requirements
- R1: A store (`cpu_we`=1) to address 0xFFFE drives `scr_char_vld` high in the following cycle, with `scr_char` equal to bits 7:0 of the stored word. `ram_we` stays low for that store.
- R2: A store of the value 0x0001 to address 0xFFFF drives `scr_clr` high in the following cycle. `ram_we` stays low for that store.
- R3: A store of any value other than 0x0001 to address 0xFFFF produces no `scr_clr` pulse and no RAM write.
- R4: A load (`cpu_re`=1) from address 0xF002 returns the LFSR state on `cpu_rdata` in the same cycle, and the state then advances one step. The first load after reset returns 0xACE1. Each step shifts the word left by one bit and inserts into bit 0 the XOR of bits 15, 13, 12 and 10. `ram_re` stays low for such a load.
- R5: A store to address 0xF002 leaves RAM unwritten and does not change the LFSR sequence seen by later loads.
- R6: A load from 0xFFFE or 0xFFFF returns 0x0000 and leaves `ram_re` low.
- R7: For any other address, `ram_addr`, `ram_wdata`, `ram_we` and `ram_re` equal the CPU-side values, and `cpu_rdata` equals `ram_rdata`, in the same cycle.
- R8: `scr_char_vld` and `scr_clr` are each high for exactly one cycle per triggering store. Back-to-back stores give back-to-back pulses, each carrying its own byte.
- R9: While reset is asserted, `scr_char_vld` and `scr_clr` are low and the LFSR is reloaded with 0xACE1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU word address |
| cpu_wdata | input | 16 | CPU store data |
| cpu_we | input | 1 | CPU store strobe |
| cpu_re | input | 1 | CPU load strobe |
| cpu_rdata | output | 16 | Load data returned to the CPU |
| ram_addr | output | 16 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_we | output | 1 | RAM write enable, gated for device addresses |
| ram_re | output | 1 | RAM read enable, gated for device addresses |
| ram_rdata | input | 16 | RAM read data |
| scr_char_vld | output | 1 | One-cycle strobe marking a new screen character |
| scr_char | output | 8 | Screen character code |
| scr_clr | output | 1 | One-cycle screen-clear strobe |

## Verification
The hardest case to reach from the ports is showing that a store to the random address really leaves the generator alone. The LFSR state is only visible through loads, so the bench wedges stores to 0xF002 between loads. It then checks that the next load still returns the next value in the sequence, not a skipped or corrupted one. A second hard case is a pair of back-to-back character stores. There the strobe must stay high for two cycles while the byte changes underneath it, and the bench drives exactly that pair.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

  // Read-data source selected by the decoder.
  typedef enum logic [1:0] {
    RSEL_RAM  = 2'd0,
    RSEL_RAND = 2'd1,
    RSEL_ZERO = 2'd2
  } rsel_e;

  // Qualified hits produced by the address decoder.
  typedef struct packed {
    logic char_wr;   // store to the character address
    logic clr_wr;    // store of the clear code to the clear address
    logic rand_rd;   // load from the random address
    logic dev;       // address belongs to any device
  } hit_t;

endpackage

// File: rtl/mmio_rst_sync.sv
module mmio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
#(
  parameter int unsigned          AW        = 16,
  parameter int unsigned          DW        = 16,
  parameter logic [AW-1:0]        CHAR_ADDR = 16'hFFFE,
  parameter logic [AW-1:0]        CLR_ADDR  = 16'hFFFF,
  parameter logic [AW-1:0]        RAND_ADDR = 16'hF002,
  parameter logic [DW-1:0]        CLR_CODE  = 16'h0001
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  input  logic          re,
  output hit_t          hits,
  output rsel_e         rsel
);

  logic char_sel, clr_sel, rand_sel;

  always_comb begin
    char_sel = (addr == CHAR_ADDR);
    clr_sel  = (addr == CLR_ADDR);
    rand_sel = (addr == RAND_ADDR);

    hits.char_wr = we & char_sel;
    hits.clr_wr  = we & clr_sel & (wdata == CLR_CODE);
    hits.rand_rd = re & rand_sel;
    hits.dev     = char_sel | clr_sel | rand_sel;

    if (rand_sel)                 rsel = RSEL_RAND;
    else if (char_sel || clr_sel) rsel = RSEL_ZERO;
    else                          rsel = RSEL_RAM;
  end

endmodule

// File: rtl/mmio_lfsr.sv
module mmio_lfsr #(
  parameter int unsigned   W    = 16,
  parameter logic [W-1:0]  TAPS = 16'hB400,
  parameter logic [W-1:0]  SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] state_q, state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = state_q;
    if (step) state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R4: a maximal-length generator never reaches the all-zero lock-up state
  a_r4_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R5: the state moves only on a qualified load
  a_r5_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state_q));

  // R4: a step shifts the previous word left by one
  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> state_q[W-1:1] == $past(state_q[W-2:0]));

endmodule

// File: rtl/mmio_screen.sv
module mmio_screen #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          char_wr,
  input  logic          clr_wr,
  input  logic [DW-1:0] wdata,
  output logic          char_vld,
  output logic [CW-1:0] char_code,
  output logic          clr
);

  logic          vld_q, vld_d;
  logic          clr_q, clr_d;
  logic [CW-1:0] code_q, code_d;

  always_comb begin
    vld_d  = char_wr;
    clr_d  = clr_wr;
    code_d = code_q;
    if (char_wr) code_d = wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      clr_q  <= 1'b0;
      code_q <= '0;
    end else begin
      vld_q  <= vld_d;
      clr_q  <= clr_d;
      code_q <= code_d;
    end
  end

  assign char_vld  = vld_q;
  assign char_code = code_q;
  assign clr       = clr_q;

  // R1 / R8: a character strobe always traces back to a store one cycle earlier
  a_r8_char_origin: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld |-> $past(char_wr));

  // R1: the strobed byte is the low byte of that store
  a_r1_char_byte: assert property (@(posedge clk) disable iff (!rst_n)
    char_wr |=> char_vld && char_code == $past(wdata[CW-1:0]));

  // R2 / R8: a clear strobe follows exactly one qualified store
  a_r2_clr_origin: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> $past(clr_wr));

endmodule

// File: rtl/mmio_steer.sv
module mmio_steer
  import mmio_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   DW        = 16,
  parameter int unsigned   CW        = 8,
  parameter logic [AW-1:0] CHAR_ADDR = 16'hFFFE,
  parameter logic [AW-1:0] CLR_ADDR  = 16'hFFFF,
  parameter logic [AW-1:0] RAND_ADDR = 16'hF002,
  parameter logic [DW-1:0] CLR_CODE  = 16'h0001,
  parameter logic [DW-1:0] RND_TAPS  = 16'hB400,
  parameter logic [DW-1:0] RND_SEED  = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_we,
  input  logic          cpu_re,
  output logic [DW-1:0] cpu_rdata,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  output logic          ram_re,
  input  logic [DW-1:0] ram_rdata,
  output logic          scr_char_vld,
  output logic [CW-1:0] scr_char,
  output logic          scr_clr
);

  logic          rst_s_n;
  hit_t          hits;
  rsel_e         rsel;
  logic [DW-1:0] rnd_word;

  mmio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s_n)
  );

  mmio_decode #(
    .AW(AW), .DW(DW), .CHAR_ADDR(CHAR_ADDR), .CLR_ADDR(CLR_ADDR),
    .RAND_ADDR(RAND_ADDR), .CLR_CODE(CLR_CODE)
  ) u_dec (
    .addr  (cpu_addr),
    .wdata (cpu_wdata),
    .we    (cpu_we),
    .re    (cpu_re),
    .hits  (hits),
    .rsel  (rsel)
  );

  mmio_lfsr #(.W(DW), .TAPS(RND_TAPS), .SEED(RND_SEED)) u_rnd (
    .clk   (clk),
    .rst_n (rst_s_n),
    .step  (hits.rand_rd),
    .state (rnd_word)
  );

  mmio_screen #(.DW(DW), .CW(CW)) u_scr (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .char_wr   (hits.char_wr),
    .clr_wr    (hits.clr_wr),
    .wdata     (cpu_wdata),
    .char_vld  (scr_char_vld),
    .char_code (scr_char),
    .clr       (scr_clr)
  );

  // RAM side: address and data pass through, strobes are withheld for devices.
  always_comb begin
    ram_addr  = cpu_addr;
    ram_wdata = cpu_wdata;
    ram_we    = cpu_we & ~hits.dev;
    ram_re    = cpu_re & ~hits.dev;
  end

  // Load data return.
  always_comb begin
    unique case (rsel)
      RSEL_RAND: cpu_rdata = rnd_word;
      RSEL_ZERO: cpu_rdata = '0;
      default:   cpu_rdata = ram_rdata;
    endcase
  end

  // R1 / R3: the screen addresses never write memory
  a_r3_no_ram_we_screen: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cpu_addr == CHAR_ADDR || cpu_addr == CLR_ADDR) |-> !ram_we);

  // R5: the random address never writes memory
  a_r5_no_ram_we_rand: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cpu_addr == RAND_ADDR) |-> !ram_we && !ram_re);

  // R6: screen addresses read back as zero without a RAM read
  a_r6_zero_read: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cpu_re && (cpu_addr == CHAR_ADDR || cpu_addr == CLR_ADDR))
      |-> cpu_rdata == '0 && !ram_re);

  // R7: ordinary addresses reach RAM unchanged
  a_r7_pass: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cpu_addr != CHAR_ADDR && cpu_addr != CLR_ADDR && cpu_addr != RAND_ADDR)
      |-> ram_we == cpu_we && ram_re == cpu_re && cpu_rdata == ram_rdata);

  // R4: a random load consumes a word that then changes
  a_r4_fresh: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cpu_re && cpu_addr == RAND_ADDR) |=> rnd_word != $past(rnd_word));

endmodule

// File: tb/mmio_steer_tb.sv
module mmio_steer_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [15:0] cpu_wdata;
  logic        cpu_we;
  logic        cpu_re;
  logic [15:0] cpu_rdata;
  logic [15:0] ram_addr;
  logic [15:0] ram_wdata;
  logic        ram_we;
  logic        ram_re;
  logic [15:0] ram_rdata;
  logic        scr_char_vld;
  logic [7:0]  scr_char;
  logic        scr_clr;

  mmio_steer u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_rdata(cpu_rdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
    .ram_rdata(ram_rdata),
    .scr_char_vld(scr_char_vld), .scr_char(scr_char), .scr_clr(scr_clr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors    = 0;
  int miscompares = 0;

  // Behavioural reference state
  logic [15:0] m_rnd;
  logic        m_vld;
  logic [7:0]  m_char;
  logic        m_clr;

  function automatic logic [15:0] rnd_next(input logic [15:0] s);
    logic b;
    b = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], b};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One CPU cycle: drive at the falling edge, check mid-cycle, advance the model at the rising edge.
  task automatic cyc(input logic we, input logic re, input logic [15:0] a,
                     input logic [15:0] wd, input logic [15:0] rd);
    string tag;
    logic  dev;
    @(negedge clk);
    cpu_we = we; cpu_re = re; cpu_addr = a; cpu_wdata = wd; ram_rdata = rd;
    #(CLK_PERIOD/4);
    dev = (a == 16'hFFFE) || (a == 16'hFFFF) || (a == 16'hF002);
    if (a == 16'hFFFE)      tag = re ? "R6" : "R1";
    else if (a == 16'hFFFF) tag = re ? "R6" : ((wd == 16'h0001) ? "R2" : "R3");
    else if (a == 16'hF002) tag = re ? "R4" : "R5";
    else                    tag = "R7";
    // registered strobes from the previous cycle
    chk(m_vld ? "R1" : "R8", "scr_char_vld", {15'd0, scr_char_vld}, {15'd0, m_vld});
    if (m_vld) chk("R8", "scr_char", {8'd0, scr_char}, {8'd0, m_char});
    chk(m_clr ? "R2" : "R3", "scr_clr", {15'd0, scr_clr}, {15'd0, m_clr});
    // combinational memory path
    chk(tag, "ram_we", {15'd0, ram_we}, {15'd0, we && !dev});
    chk(tag, "ram_re", {15'd0, ram_re}, {15'd0, re && !dev});
    if (!dev) begin
      chk("R7", "ram_addr", ram_addr, a);
      chk("R7", "ram_wdata", ram_wdata, wd);
    end
    if (re) begin
      if (a == 16'hF002) chk(tag, "cpu_rdata", cpu_rdata, m_rnd);
      else if (dev)      chk(tag, "cpu_rdata", cpu_rdata, 16'h0000);
      else               chk(tag, "cpu_rdata", cpu_rdata, rd);
    end
    @(posedge clk);
    m_vld = we && (a == 16'hFFFE);
    if (m_vld) m_char = wd[7:0];
    m_clr = we && (a == 16'hFFFF) && (wd == 16'h0001);
    if (re && a == 16'hF002) m_rnd = rnd_next(m_rnd);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    cpu_addr = '0; cpu_wdata = '0; cpu_we = 1'b0; cpu_re = 1'b0; ram_rdata = '0;
    m_vld = 1'b0; m_clr = 1'b0; m_char = '0; m_rnd = 16'hACE1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    // R9: strobes low during reset, even with a character store presented
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = 16'hFFFE; cpu_wdata = 16'h0055;
    @(posedge clk);
    @(negedge clk);
    cpu_we = 1'b0;
    #(CLK_PERIOD/4);
    chk("R9", "scr_char_vld in reset", {15'd0, scr_char_vld}, 16'd0);
    chk("R9", "scr_clr in reset", {15'd0, scr_clr}, 16'd0);
    rst_n = 1'b1;
    repeat (3) idle();

    // R9 / R4: first random load returns the seed, then the sequence
    cyc(1'b0, 1'b1, 16'hF002, 16'h0000, 16'h1234);
    cyc(1'b0, 1'b1, 16'hF002, 16'h0000, 16'h1234);
    idle();
    cyc(1'b0, 1'b1, 16'hF002, 16'h0000, 16'h1234);

    // R1: character store, then R8 back-to-back stores
    cyc(1'b1, 1'b0, 16'hFFFE, 16'h3C41, 16'h0000);
    idle();
    cyc(1'b1, 1'b0, 16'hFFFE, 16'h0042, 16'h0000);
    cyc(1'b1, 1'b0, 16'hFFFE, 16'hFF43, 16'h0000);
    idle();

    // R2 / R3: clear codes
    cyc(1'b1, 1'b0, 16'hFFFF, 16'h0001, 16'h0000);
    idle();
    cyc(1'b1, 1'b0, 16'hFFFF, 16'h0002, 16'h0000);
    cyc(1'b1, 1'b0, 16'hFFFF, 16'h0101, 16'h0000);
    cyc(1'b1, 1'b0, 16'hFFFF, 16'h0000, 16'h0000);
    idle();

    // R5: stores to the random address between loads
    cyc(1'b1, 1'b0, 16'hF002, 16'h0000, 16'h0000);
    cyc(1'b1, 1'b0, 16'hF002, 16'hFFFF, 16'h0000);
    cyc(1'b0, 1'b1, 16'hF002, 16'h0000, 16'h0000);

    // R6: screen addresses read as zero
    cyc(1'b0, 1'b1, 16'hFFFE, 16'h0000, 16'hBEEF);
    cyc(1'b0, 1'b1, 16'hFFFF, 16'h0000, 16'hBEEF);

    // R7: ordinary traffic, including neighbours of device addresses
    cyc(1'b1, 1'b0, 16'h0000, 16'h1111, 16'h0000);
    cyc(1'b0, 1'b1, 16'hFFFD, 16'h0000, 16'hA5A5);
    cyc(1'b1, 1'b0, 16'hF003, 16'h7777, 16'h0000);
    cyc(1'b0, 1'b1, 16'hF001, 16'h0000, 16'h5A5A);

    // Mixed traffic across all address kinds
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [15:0] wd;
      logic        w;
      int          k;
      k  = $urandom_range(0, 5);
      case (k)
        0: a = 16'hFFFE;
        1: a = 16'hFFFF;
        2: a = 16'hF002;
        default: a = 16'($urandom);
      endcase
      wd = ($urandom_range(0, 3) == 0) ? 16'h0001 : 16'($urandom);
      w  = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 4) == 0) idle();
      else cyc(w, !w, a, wd, 16'($urandom));
    end
    idle();
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule